// File: doc/BRIEF.md
# Pseudo-DMA READY Trap Controller

This block lets a processor act as its own DMA engine when sector bytes move between a floppy disk controller and memory. Software arms the trap and then runs a tight loop. Each pass first touches a trap address. While the controller has no byte ready, that access holds the processor's READY line low. When the controller raises its data request, READY is released and the stalled cycle finishes. The loop then reads a read-data address, or writes a write-data address. Either access pulses the active-low DMA acknowledge, so the byte crosses the shared data bus and the controller drops its request.

A timeout input from an external watchdog monoflop forces READY high. A sector access that never produces a data request therefore cannot hang the processor. After the loop, software tells a timeout from a finished sector by testing that monoflop. The block also counts data-port acknowledges up to the sector length. Cycles flagged as on-chip memory cycles never see READY, so they are neither trapped nor acknowledged. Software can pulse acknowledge directly to clear a request that was left pending by an earlier aborted transfer. Without that pulse, the first byte of the next transfer would slip past the trap.

None of the pins carries a data stream through the block. The bytes travel on the processor's own bus, so every port is a plain control or status signal with no back-pressure.

Top module: `pdma_ready_trap`

## Requirements
- R1: While `arm` is 0, `cpu_ready` is 1 and `trap_active` is 0, whatever the bus does.
- R2: When armed, with `tmo_expired` low and `dreq` low, an external read or write to `TRAP_ADDR` sets `trap_active` from the next clock. `cpu_ready` stays 0 while `trap_active`, `arm` and the low levels of `dreq` and `tmo_expired` all persist.
- R3: While `dreq` is 1, `cpu_ready` is 1 in that same cycle, and `trap_active` is 0 from the next clock.
- R4: An external read of `RD_ADDR` or an external write of `WR_ADDR` drives `dack_n` to 0 for exactly the following clock. A write to `RD_ADDR` or a read of `WR_ADDR` gives no acknowledge.
- R5: A one-clock `ack_force` pulse drives `dack_n` to 0 for the following clock and leaves `xfer_count` unchanged.
- R6: While `tmo_expired` is 1, `cpu_ready` is 1. `trap_active` is 0 from the next clock, and trap accesses do not stall.
- R7: While armed, each data-port acknowledge (R4) raises `xfer_count` by one, saturating at `SECTOR_BYTES` (default 256). `sector_done` is 1 exactly when the count equals `SECTOR_BYTES`. While `arm` is 0, the count returns to 0 on the next clock.
- R8: A cycle with `bus_internal` = 1 neither sets the trap nor produces an acknowledge, whatever its address.
- R9: Accesses to any other address have no effect on `trap_active`, `dack_n` or `xfer_count`.
- R10: During and right after reset: `cpu_ready` = 1, `dack_n` = 1, `trap_active` = 0, `xfer_count` = 0, `sector_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Trap enable from a control bit |
| ack_force | input | 1 | Software pulse that forces one acknowledge |
| tmo_expired | input | 1 | Watchdog monoflop has run out (1 = expired) |
| dreq | input | 1 | Data request from the floppy controller |
| bus_addr | input | AW (16) | Processor address |
| bus_rd | input | 1 | Read cycle strobe |
| bus_wr | input | 1 | Write cycle strobe |
| bus_internal | input | 1 | Cycle targets on-chip memory |
| cpu_ready | output | 1 | READY to the processor (0 = stall) |
| dack_n | output | 1 | Active-low DMA acknowledge to the controller |
| trap_active | output | 1 | Processor is held in the trap |
| xfer_count | output | CW (9) | Data-port acknowledges since arming |
| sector_done | output | 1 | Count has reached SECTOR_BYTES |

## Verification
The directed cases cover a full stall-and-release pass, a read and a write acknowledge, and swapped direction strobes on the data ports. They also cover a forced acknowledge, a timeout during a stall, on-chip cycles and a full sector count with saturation. Each of these separates one decode or gating path from the others. The random phase mixes arm, timeout, request and forced-acknowledge levels with addresses biased toward the three decoded ports. It exercises orderings the directed cases miss, such as a request arriving in the same clock as the trap access, or a timeout arriving while an acknowledge is in flight.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef struct packed {
    logic trap;   // access to the trap address
    logic rd;     // read of the read-data port
    logic wr;     // write of the write-data port
  } pdma_hits_t;
endpackage

// File: rtl/pdma_addr_decode.sv
module pdma_addr_decode
  import pdma_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] TRAP_ADDR = 16'hC010,
  parameter logic [AW-1:0] RD_ADDR   = 16'hC012,
  parameter logic [AW-1:0] WR_ADDR   = 16'hC014
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_internal,
  output pdma_hits_t    hits
);
  logic ext_cycle;

  // on-chip cycles never observe READY, so they are left alone
  assign ext_cycle = !bus_internal;

  always_comb begin
    hits.trap = ext_cycle && (bus_rd || bus_wr) && (bus_addr == TRAP_ADDR);
    hits.rd   = ext_cycle && bus_rd && (bus_addr == RD_ADDR);
    hits.wr   = ext_cycle && bus_wr && (bus_addr == WR_ADDR);
  end
endmodule

// File: rtl/pdma_ready_gate.sv
module pdma_ready_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tmo_expired,
  input  logic dreq,
  input  logic trap_hit,
  output logic cpu_ready,
  output logic trap_active
);
  logic trap_q;
  logic hold_ok;

  assign hold_ok = arm && !tmo_expired && !dreq;

  always_ff @(posedge clk) begin
    if (!rst_n)        trap_q <= 1'b0;
    else if (!hold_ok) trap_q <= 1'b0;
    else if (trap_hit) trap_q <= 1'b1;
  end

  assign trap_active = trap_q;
  assign cpu_ready   = !(trap_q && hold_ok);

  AST_DISARMED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> cpu_ready); // R1
  AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_hit && hold_ok) |=> trap_active); // R2
  AST_DREQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |=> !trap_active); // R3
  AST_TMO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expired |-> cpu_ready); // R6
endmodule

// File: rtl/pdma_ack_gen.sv
module pdma_ack_gen #(
  parameter int SECTOR_BYTES = 256,
  localparam int CW = $clog2(SECTOR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          ack_force,
  input  logic          rd_hit,
  input  logic          wr_hit,
  output logic          dack_n,
  output logic [CW-1:0] xfer_count,
  output logic          sector_done
);
  localparam logic [CW-1:0] LAST = CW'(SECTOR_BYTES);

  logic          dack_q;
  logic [CW-1:0] cnt_q;
  logic          data_hit;

  assign data_hit = rd_hit || wr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) dack_q <= 1'b0;
    else        dack_q <= data_hit || ack_force;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !arm)              cnt_q <= '0;
    else if (data_hit && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign dack_n      = !dack_q;
  assign xfer_count  = cnt_q;
  assign sector_done = (cnt_q == LAST);

  AST_DACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |=> !dack_n); // R4
  AST_FORCE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_force && !data_hit && arm) |=> (!dack_n && $stable(xfer_count))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_count <= LAST); // R7
  AST_DISARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (xfer_count == '0)); // R7
endmodule

// File: rtl/pdma_ready_trap.sv
module pdma_ready_trap
  import pdma_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] TRAP_ADDR = 16'hC010,
  parameter logic [AW-1:0] RD_ADDR   = 16'hC012,
  parameter logic [AW-1:0] WR_ADDR   = 16'hC014,
  parameter int SECTOR_BYTES = 256,
  localparam int CW = $clog2(SECTOR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          ack_force,
  input  logic          tmo_expired,
  input  logic          dreq,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_internal,
  output logic          cpu_ready,
  output logic          dack_n,
  output logic          trap_active,
  output logic [CW-1:0] xfer_count,
  output logic          sector_done
);
  pdma_hits_t hits;

  pdma_addr_decode #(
    .AW(AW), .TRAP_ADDR(TRAP_ADDR), .RD_ADDR(RD_ADDR), .WR_ADDR(WR_ADDR)
  ) u_decode (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_internal(bus_internal), .hits(hits)
  );

  pdma_ready_gate u_gate (
    .clk(clk), .rst_n(rst_n), .arm(arm), .tmo_expired(tmo_expired),
    .dreq(dreq), .trap_hit(hits.trap),
    .cpu_ready(cpu_ready), .trap_active(trap_active)
  );

  pdma_ack_gen #(.SECTOR_BYTES(SECTOR_BYTES)) u_ack (
    .clk(clk), .rst_n(rst_n), .arm(arm), .ack_force(ack_force),
    .rd_hit(hits.rd), .wr_hit(hits.wr),
    .dack_n(dack_n), .xfer_count(xfer_count), .sector_done(sector_done)
  );

  AST_INTERNAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_internal && !ack_force && !trap_active) |=> (dack_n && !trap_active)); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (cpu_ready && dack_n && !trap_active && xfer_count == '0)); // R10
endmodule

// File: tb/test_pdma_ready_trap.sv
module test_pdma_ready_trap;
  localparam logic [15:0] TA = 16'hC010;
  localparam logic [15:0] RA = 16'hC012;
  localparam logic [15:0] WA = 16'hC014;
  localparam int NB = 256;

  logic clk = 1'b0;
  logic rst_n, arm, ack_force, tmo_expired, dreq, bus_rd, bus_wr, bus_internal;
  logic [15:0] bus_addr;
  logic cpu_ready, dack_n, trap_active, sector_done;
  logic [8:0] xfer_count;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic m_trap;
  logic m_dack;
  int   m_cnt;

  always #2.5 clk = ~clk;

  pdma_ready_trap i_pdma_ready_trap (
    .clk(clk), .rst_n(rst_n), .arm(arm), .ack_force(ack_force),
    .tmo_expired(tmo_expired), .dreq(dreq), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_internal(bus_internal),
    .cpu_ready(cpu_ready), .dack_n(dack_n), .trap_active(trap_active),
    .xfer_count(xfer_count), .sector_done(sector_done)
  );

  function automatic bit f_trap_hit(logic [15:0] a, logic r, logic w, logic in);
    return !in && (r || w) && a == TA;
  endfunction
  function automatic bit f_data_hit(logic [15:0] a, logic r, logic w, logic in);
    return !in && ((r && a == RA) || (w && a == WA));
  endfunction
  function automatic bit f_ready(logic tr, logic a, logic t, logic d);
    return !(tr && a && !t && !d);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check just after
  task automatic step(input logic a, input logic af, input logic t, input logic d,
                      input logic [15:0] ad, input logic r, input logic w, input logic in);
    bit th, dh;
    @(negedge clk);
    arm = a; ack_force = af; tmo_expired = t; dreq = d;
    bus_addr = ad; bus_rd = r; bus_wr = w; bus_internal = in;
    th = f_trap_hit(ad, r, w, in);
    dh = f_data_hit(ad, r, w, in);
    @(posedge clk);
    m_trap = (a && !t && !d) ? (m_trap || th) : 1'b0;
    m_dack = dh || af;
    if (!a) m_cnt = 0;
    else if (dh && m_cnt < NB) m_cnt++;
    #1;
    chk("R2", "trap_active", trap_active, m_trap);
    chk("R3", "cpu_ready", cpu_ready, f_ready(m_trap, a, t, d));
    chk("R4", "dack_n", dack_n, !m_dack);
    chk("R7", "xfer_count", xfer_count, m_cnt);
    chk("R7", "sector_done", sector_done, m_cnt == NB);
  endtask

  task automatic idle(input logic a, input logic t, input logic d);
    step(a, 0, t, d, 16'h0000, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_trap = 0; m_dack = 0; m_cnt = 0;
    rst_n = 0; arm = 0; ack_force = 0; tmo_expired = 0; dreq = 0;
    bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_internal = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", "cpu_ready", cpu_ready, 1);
    chk("R10", "dack_n", dack_n, 1);
    chk("R10", "trap_active", trap_active, 0);
    chk("R10", "xfer_count", xfer_count, 0);
    chk("R10", "sector_done", sector_done, 0);
    @(negedge clk); rst_n = 1;

    // R1 disarmed trap access never stalls
    step(0, 0, 0, 0, TA, 1, 0, 0);
    chk("R1", "cpu_ready disarmed", cpu_ready, 1);
    idle(0, 0, 0);

    // R2 armed trap access, stall held for several clocks
    step(1, 0, 0, 0, TA, 0, 1, 0);
    chk("R2", "stall", cpu_ready, 0);
    idle(1, 0, 0); idle(1, 0, 0);
    chk("R2", "stall held", cpu_ready, 0);
    // R3 request releases in the same cycle
    idle(1, 0, 1);
    chk("R3", "release", cpu_ready, 1);
    chk("R3", "trap cleared", trap_active, 0);
    // R4 read of read port acks; then request dropped
    step(1, 0, 0, 1, RA, 1, 0, 0);
    chk("R4", "read ack", dack_n, 0);
    idle(1, 0, 0);
    chk("R4", "ack one clock", dack_n, 1);
    // R4 write of write port acks; swapped strobes do not
    step(1, 0, 0, 0, WA, 0, 1, 0);
    chk("R4", "write ack", dack_n, 0);
    step(1, 0, 0, 0, RA, 0, 1, 0);
    chk("R4", "write to read port", dack_n, 1);
    step(1, 0, 0, 0, WA, 1, 0, 0);
    chk("R4", "read of write port", dack_n, 1);
    // R5 forced ack does not count
    step(1, 1, 0, 1, 16'h0000, 0, 0, 0);
    chk("R5", "forced ack", dack_n, 0);
    chk("R5", "count kept", xfer_count, 2);
    // R6 timeout breaks a stall and prevents new ones
    step(1, 0, 0, 0, TA, 1, 0, 0);
    chk("R6", "stalled first", cpu_ready, 0);
    idle(1, 1, 0);
    chk("R6", "timeout ready", cpu_ready, 1);
    chk("R6", "timeout trap", trap_active, 0);
    step(1, 0, 1, 0, TA, 1, 0, 0);
    chk("R6", "no stall on timeout", trap_active, 0);
    // R8 internal cycles are ignored
    step(1, 0, 0, 0, TA, 1, 0, 1);
    chk("R8", "internal trap", trap_active, 0);
    step(1, 0, 0, 0, RA, 1, 0, 1);
    chk("R8", "internal ack", dack_n, 1);
    // R9 unrelated address
    step(1, 0, 0, 0, 16'hC016, 1, 1, 0);
    chk("R9", "other addr trap", trap_active, 0);
    chk("R9", "other addr ack", dack_n, 1);
    // R7 full sector and saturation, then disarm clears
    idle(0, 0, 0);
    for (int i = 0; i < NB + 3; i++) step(1, 0, 0, 1, RA, 1, 0, 0);
    chk("R7", "saturated", xfer_count, NB);
    chk("R7", "done", sector_done, 1);
    idle(0, 0, 0);
    chk("R7", "disarm clears", xfer_count, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ad;
      int sel = $urandom_range(0, 3);
      int op  = $urandom_range(0, 2);
      ad = (sel == 0) ? TA : (sel == 1) ? RA : (sel == 2) ? WA : 16'($urandom());
      step($urandom_range(0, 15) != 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0, $urandom_range(0, 2) == 0,
           ad, op == 1, op == 2, $urandom_range(0, 7) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule